// File: doc/BRIEF.md
# Capture Compare Timer

A 16-bit free-running counter with one input-capture channel and one output-compare channel, reached through a byte-wide register bus. The counter advances once every four clocks. A chosen edge on the capture input copies the count into a capture register. When the counter steps onto the value held in the compare register, the compare output takes a programmed level. Wrap, capture and compare each raise a status flag, and each flag has its own interrupt enable feeding a single request line.

Since the count is wider than the bus, reading the high byte of a count view freezes the matching low byte until that low byte is read. Two count views exist. The main view takes part in clearing the wrap flag. The second view never does, so software can sample the time without disturbing a pending wrap. A flag is cleared in two steps: first a status read taken while the flag is set, then a specific data-byte access.

Top module: `cap_cmp_timer`

## Requirements
- R1: After reset the count is 0xFFFC. It then grows by one every fourth clock, starting on the fourth clock edge after reset is released, and wraps from 0xFFFF to 0x0000.
- R2: Register map (4-bit address): 0 control, 1 status, 2/3 main count high/low, 4/5 second count view high/low, 6/7 capture high/low, 8/9 compare high/low. Reading address 2 or 4 freezes that view's low byte. The next read of address 3 or 5 returns the frozen byte and releases it. A low-byte read with nothing frozen returns the live value.
- R3: Status bit 0 (wrap flag) is set when the count steps from 0xFFFF to 0x0000. Reset leaves this flag as it was.
- R4: The wrap flag is cleared only by a status read that finds it set, followed by a read of address 3. Reads of addresses 4 and 5 never clear it.
- R5: Control bit 0 picks the capture edge: 1 for rising, 0 for falling. The input goes through a two-stage synchronizer. If the pin changes just after clock edge k, the captured value is the count that holds after edge k+2, and status bit 1 is set. The other edge is ignored.
- R6: Status bit 1 is cleared by a status read that finds it set, followed by a read of address 7. Without that status read, the address 7 read leaves it set.
- R7: Reset clears status bit 1 and the captured value, whatever edges came before.
- R8: One clock after the count steps onto the compare value, the compare output takes the level of control bit 1, and status bit 2 is set.
- R9: A write to address 8 blocks compares until address 9 is written. Compares are also blocked from reset until the first write to address 9.
- R10: Status bit 2 is cleared by a status read that finds it set, followed by a write to address 9. Without that status read, the write leaves it set.
- R11: Control bits 2, 3 and 4 enable the wrap, capture and compare flags onto the interrupt line, which is the OR of each flag ANDed with its enable. Reset clears the control register to 0x00 and drives the compare output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_in | input | 1 | Capture pin (asynchronous) |
| cmp_out | output | 1 | Compare pin |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, one clock per read; side effects take effect at the edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase or counter value shows up in every count read and also shifts the compare pin by whole four-clock steps. So the bench predicts every count from the number of edges since reset and checks it to the clock. A faulty freeze buffer or clear-arming bit only shows up on the second access of a pair. For that reason each two-step sequence is also run with the first step left out, and with the second step sent to the wrong view. A lost block on the compare register would move the pin many clocks before the intended match, so the pin is sampled after a blocked target has been passed.

// File: rtl/ccmp_pkg.sv
// Shared widths, register addresses and bit positions for the capture
// compare timer. Assumes an 8-bit bus and a count of two bytes.
package ccmp_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 4'd0,
        A_STAT   = 4'd1,
        A_CNT_HI = 4'd2,
        A_CNT_LO = 4'd3,
        A_ALT_HI = 4'd4,
        A_ALT_LO = 4'd5,
        A_CAP_HI = 4'd6,
        A_CAP_LO = 4'd7,
        A_CMP_HI = 4'd8,
        A_CMP_LO = 4'd9
    } reg_addr_e;

    localparam int CTL_EDGE   = 0;
    localparam int CTL_LVL    = 1;
    localparam int CTL_OVF_IE = 2;
    localparam int CTL_CAP_IE = 3;
    localparam int CTL_CMP_IE = 4;

    localparam int ST_OVF = 0;
    localparam int ST_CAP = 1;
    localparam int ST_CMP = 2;
endpackage

// File: rtl/ccmp_prescale.sv
// Clock divider: gives a one-clock tick every DIV clocks.
// Assumes DIV >= 2. The phase restarts at reset, so the first tick
// falls on the DIV-th edge after release.
module ccmp_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] ph_q;

    // phase counter, wraps at DIV-1
    always_ff @(posedge clk) begin
        if (!rst_n)            ph_q <= '0;
        else if (ph_q == LAST) ph_q <= '0;
        else                   ph_q <= ph_q + 1'b1;
    end

    assign tick = (ph_q == LAST);
endmodule

// File: rtl/ccmp_counter.sv
// Free-running W-bit counter that moves one step on each tick.
// step marks the clock after a move, i.e. while the new value is visible.
// wrap marks the tick that carries the all-ones value over to zero.
module ccmp_counter #(
    parameter int W = 16,
    parameter logic [W-1:0] RST_VAL = {W{1'b1}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         step,
    output logic         wrap
);
    logic [W-1:0] cnt_q;
    logic         step_q;

    // count register and the step marker that follows a move
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= RST_VAL;
            step_q <= 1'b0;
        end else begin
            step_q <= tick;
            if (tick) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt  = cnt_q;
    assign step = step_q;
    assign wrap = tick && (cnt_q == {W{1'b1}});
endmodule

// File: rtl/ccmp_capture.sv
// Capture channel: synchronizes the pin, detects the selected edge and
// copies the count at that moment. Assumes STAGES >= 2.
// Reset clears the stored value.
module ccmp_capture #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin,
    input  logic         rise_sel,
    input  logic [W-1:0] cnt,
    output logic         evt,
    output logic [W-1:0] val
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic [W-1:0]      val_q;
    logic              now_lvl;

    assign now_lvl = sync_q[STAGES-1];

    // synchronizer chain and the previous level used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            prev_q <= now_lvl;
        end
    end

    assign evt = rise_sel ? (now_lvl && !prev_q) : (!now_lvl && prev_q);

    // capture register, loaded on the selected edge
    always_ff @(posedge clk) begin
        if (!rst_n)   val_q <= '0;
        else if (evt) val_q <= cnt;
    end

    assign val = val_q;
endmodule

// File: rtl/ccmp_compare.sv
// Compare channel: on the clock after the count moves onto the target,
// and only if enabled, raises hit and drives the pin to the given level.
// The pin is low after reset.
module ccmp_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         enable,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] target,
    input  logic         level,
    output logic         hit,
    output logic         pin
);
    logic pin_q;

    assign hit = step && enable && (cnt == target);

    // output pin register
    always_ff @(posedge clk) begin
        if (!rst_n)   pin_q <= 1'b0;
        else if (hit) pin_q <= level;
    end

    assign pin = pin_q;
endmodule

// File: rtl/cap_cmp_timer.sv
// Capture compare timer top: register bus, two count views that freeze
// their low byte, flags with two-step clearing, and the interrupt.
// Assumes one-clock bus_rd/bus_wr strobes. Reads are combinational and
// their side effects take hold at the clock edge.
module cap_cmp_timer
    import ccmp_pkg::*;
#(
    parameter int           PRESCALE    = 4,
    parameter int           SYNC_STAGES = 2,
    parameter logic [15:0]  RST_COUNT   = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_in,
    output logic              cmp_out,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int NVIEW = 2;

    logic              tick, step, wrap;
    logic [CNT_W-1:0]  cnt_q;
    logic              cap_evt, cmp_hit;
    logic [CNT_W-1:0]  cap_val;
    logic [BYTE_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  cmp_q;
    logic              blocked_q;
    logic              ovf_q, cap_q, cmp_f_q;
    logic              arm_ovf_q, arm_cap_q, arm_cmp_q;
    logic              rd_stat, clr_ovf, clr_cap, clr_cmp;
    logic              wr_ctrl, wr_cmp_hi, wr_cmp_lo;
    logic [BYTE_W-1:0] view_lo [NVIEW];

    ccmp_prescale #(.DIV(PRESCALE)) i_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    ccmp_counter #(.W(CNT_W), .RST_VAL(RST_COUNT)) i_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt(cnt_q), .step(step), .wrap(wrap)
    );

    ccmp_capture #(.W(CNT_W), .STAGES(SYNC_STAGES)) i_cap (
        .clk(clk), .rst_n(rst_n), .pin(cap_in),
        .rise_sel(ctrl_q[CTL_EDGE]), .cnt(cnt_q),
        .evt(cap_evt), .val(cap_val)
    );

    ccmp_compare #(.W(CNT_W)) i_cmp (
        .clk(clk), .rst_n(rst_n), .step(step), .enable(!blocked_q),
        .cnt(cnt_q), .target(cmp_q), .level(ctrl_q[CTL_LVL]),
        .hit(cmp_hit), .pin(cmp_out)
    );

    assign rd_stat   = bus_rd && (bus_addr == A_STAT);
    assign clr_ovf   = bus_rd && (bus_addr == A_CNT_LO) && arm_ovf_q;
    assign clr_cap   = bus_rd && (bus_addr == A_CAP_LO) && arm_cap_q;
    assign clr_cmp   = bus_wr && (bus_addr == A_CMP_LO) && arm_cmp_q;
    assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
    assign wr_cmp_hi = bus_wr && (bus_addr == A_CMP_HI);
    assign wr_cmp_lo = bus_wr && (bus_addr == A_CMP_LO);

    // per-view low-byte freeze for coherent two-byte reads
    for (genvar v = 0; v < NVIEW; v++) begin : g_view
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(A_CNT_HI + 2 * v);
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(A_CNT_HI + 2 * v + 1);
        logic              hold_q;
        logic [BYTE_W-1:0] buf_q;

        // freeze on high-byte read, release on low-byte read
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q <= 1'b0;
                buf_q  <= '0;
            end else if (bus_rd && bus_addr == HI_A) begin
                hold_q <= 1'b1;
                buf_q  <= cnt_q[BYTE_W-1:0];
            end else if (bus_rd && bus_addr == LO_A) begin
                hold_q <= 1'b0;
            end
        end

        assign view_lo[v] = hold_q ? buf_q : cnt_q[BYTE_W-1:0];
    end

    // control and compare registers, compare block flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            cmp_q     <= '0;
            blocked_q <= 1'b1;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata;
            if (wr_cmp_hi) begin
                cmp_q[CNT_W-1:BYTE_W] <= bus_wdata;
                blocked_q             <= 1'b1;
            end
            if (wr_cmp_lo) begin
                cmp_q[BYTE_W-1:0] <= bus_wdata;
                blocked_q         <= 1'b0;
            end
        end
    end

    // wrap flag: deliberately outside reset, set wins over clear
    always_ff @(posedge clk) begin
        if (wrap)         ovf_q <= 1'b1;
        else if (clr_ovf) ovf_q <= 1'b0;
    end

    // capture and compare flags, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q   <= 1'b0;
            cmp_f_q <= 1'b0;
        end else begin
            if (cap_evt)      cap_q <= 1'b1;
            else if (clr_cap) cap_q <= 1'b0;
            if (cmp_hit)      cmp_f_q <= 1'b1;
            else if (clr_cmp) cmp_f_q <= 1'b0;
        end
    end

    // arming bits: a status read records which flags it saw set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_ovf_q <= 1'b0;
            arm_cap_q <= 1'b0;
            arm_cmp_q <= 1'b0;
        end else if (rd_stat) begin
            arm_ovf_q <= ovf_q;
            arm_cap_q <= cap_q;
            arm_cmp_q <= cmp_f_q;
        end else begin
            if (clr_ovf) arm_ovf_q <= 1'b0;
            if (clr_cap) arm_cap_q <= 1'b0;
            if (clr_cmp) arm_cmp_q <= 1'b0;
        end
    end

    // read data selection
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:   bus_rdata = ctrl_q;
            A_STAT:   bus_rdata = {5'b0, cmp_f_q, cap_q, ovf_q};
            A_CNT_HI: bus_rdata = cnt_q[CNT_W-1:BYTE_W];
            A_CNT_LO: bus_rdata = view_lo[0];
            A_ALT_HI: bus_rdata = cnt_q[CNT_W-1:BYTE_W];
            A_ALT_LO: bus_rdata = view_lo[1];
            A_CAP_HI: bus_rdata = cap_val[CNT_W-1:BYTE_W];
            A_CAP_LO: bus_rdata = cap_val[BYTE_W-1:0];
            A_CMP_HI: bus_rdata = cmp_q[CNT_W-1:BYTE_W];
            A_CMP_LO: bus_rdata = cmp_q[BYTE_W-1:0];
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = (ovf_q   && ctrl_q[CTL_OVF_IE])
              || (cap_q   && ctrl_q[CTL_CAP_IE])
              || (cmp_f_q && ctrl_q[CTL_CMP_IE]);
endmodule

// File: rtl/cap_cmp_timer_chk.sv
// Property checker for cap_cmp_timer, attached through bind below.
// It looks at the count, the flags, the capture value and the bus.
module cap_cmp_timer_chk
    import ccmp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  cnt,
    input logic              ovf,
    input logic              cap_flag,
    input logic [CNT_W-1:0]  cap_val,
    input logic              cmp_out,
    input logic              lvl
);
    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> cnt == $past(cnt) + 1'b1);

    // R3
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(cnt) == {CNT_W{1'b1}});

    // R4
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf) |-> $past(bus_rd && bus_addr == A_CNT_LO));

    // R4
    alt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_ALT_LO && ovf) |=> ovf);

    // R5
    cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_flag) |-> cap_val == $past(cnt));

    // R8
    pin_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_out) |-> cmp_out == $past(lvl));
endmodule

bind cap_cmp_timer cap_cmp_timer_chk i_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .cnt(cnt_q), .ovf(ovf_q), .cap_flag(cap_q), .cap_val(cap_val),
    .cmp_out(cmp_out), .lvl(ctrl_q[ccmp_pkg::CTL_LVL])
);

// File: tb/test_cap_cmp_timer.sv
// Scoreboard bench: driver tasks queue expected items, a monitor pops
// and compares them in the middle of the low clock phase.
module test_cap_cmp_timer;
    localparam logic [15:0] RST = 16'hFFFC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cap_in = 1'b0;
    logic       cmp_out;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        logic [7:0] mask;
        string      req;
    } item_t;

    item_t sb[$];
    logic  mon_go = 1'b0;
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 0;

    always #10 clk = ~clk;

    cap_cmp_timer i_cap_cmp_timer (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .cmp_out(cmp_out),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // edges since the last reset release
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    function automatic logic [15:0] cv(input int k);
        return 16'(32'(RST) + k / 4);
    endfunction

    // monitor: pops one expected item per marked cycle
    initial forever begin
        @(negedge clk);
        #5;
        if (mon_go) begin
            item_t it;
            logic [7:0] got;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: empty queue, got %h expected an item", bus_rdata);
            end else begin
                it = sb.pop_front();
                case (it.kind)
                    0:       got = bus_rdata;
                    1:       got = {7'b0, cmp_out};
                    default: got = {7'b0, irq};
                endcase
                checks++;
                if ((got & it.mask) !== (it.exp & it.mask)) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h (mask %h)",
                             it.req, got & it.mask, it.exp & it.mask, it.mask);
                end
            end
        end
    end

    task automatic rd(input logic [3:0] a, input logic [7:0] e,
                      input logic [7:0] m, input string r);
        bus_addr = a; bus_rd = 1'b1; mon_go = 1'b1;
        sb.push_back('{0, e, m, r});
        @(negedge clk);
        bus_rd = 1'b0; mon_go = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pk(input int kind, input logic e, input string r);
        mon_go = 1'b1;
        sb.push_back('{kind, {7'b0, e}, 8'h01, r});
        @(negedge clk);
        mon_go = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_to(input int k);
        while (cyc < k) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run not finished, got timeout expected completion");
        summary();
    end

    initial begin
        int kc;
        logic [15:0] cap_exp;
        idle(3);
        rst_n = 1'b1;
        // reset state
        rd(4'd0, 8'h00, 8'hFF, "R11 control reset");
        rd(4'd1, 8'h00, 8'h06, "R7 status reset");
        pk(1, 1'b0, "R11 compare pin reset");
        // coherent read across the wrap
        wait_to(15);
        rd(4'd2, cv(15)[15:8], 8'hFF, "R1 count high before wrap");
        rd(4'd3, cv(15)[7:0],  8'hFF, "R2 frozen low byte");
        rd(4'd1, 8'h01, 8'h01, "R3 wrap flag set");
        wr(4'd0, 8'h04);
        pk(2, 1'b1, "R11 wrap interrupt");
        wait_to(27);
        rd(4'd4, cv(27)[15:8], 8'hFF, "R2 second view high");
        rd(4'd5, cv(27)[7:0],  8'hFF, "R2 second view frozen low");
        rd(4'd1, 8'h01, 8'h01, "R4 second view keeps wrap flag");
        // reset keeps the wrap flag
        do_reset();
        rd(4'd3, 8'h00, 8'h00, "R4 unarmed low read");
        rd(4'd1, 8'h01, 8'h01, "R3 wrap flag survives reset");
        rd(4'd0, 8'h00, 8'hFF, "R11 control cleared by reset");
        pk(2, 1'b0, "R11 interrupt off after reset");
        wait_to(20);
        rd(4'd5, 8'h00, 8'h00, "R4 second view low read");
        rd(4'd1, 8'h01, 8'h01, "R4 flag still set");
        rd(4'd3, 8'h00, 8'h00, "R4 clearing low read");
        rd(4'd1, 8'h00, 8'h01, "R4 wrap flag cleared");
        wait_to(1039);
        rd(4'd2, cv(1039)[15:8], 8'hFF, "R1 count high at 0x00FF");
        rd(4'd3, cv(1039)[7:0],  8'hFF, "R2 frozen low at carry");
        // capture, rising edge
        wr(4'd0, 8'h01);
        kc = cyc; cap_in = 1'b1; cap_exp = cv(kc + 2);
        idle(4);
        rd(4'd6, cap_exp[15:8], 8'hFF, "R5 rising capture high");
        rd(4'd1, 8'h02, 8'h02, "R5 capture flag set");
        cap_in = 1'b0;
        idle(4);
        rd(4'd6, cap_exp[15:8], 8'hFF, "R5 falling edge ignored high");
        rd(4'd7, cap_exp[7:0],  8'hFF, "R5 falling edge ignored low");
        rd(4'd1, 8'h00, 8'h02, "R6 capture flag cleared");
        // capture, falling edge
        wr(4'd0, 8'h00);
        cap_in = 1'b1;
        idle(4);
        rd(4'd1, 8'h00, 8'h02, "R5 rising edge ignored in falling mode");
        kc = cyc; cap_in = 1'b0; cap_exp = cv(kc + 2);
        idle(4);
        rd(4'd7, cap_exp[7:0], 8'hFF, "R5 falling capture low");
        rd(4'd1, 8'h02, 8'h02, "R6 flag kept without status read");
        wr(4'd0, 8'h08);
        pk(2, 1'b1, "R11 capture interrupt");
        // reset clears capture
        do_reset();
        rd(4'd1, 8'h00, 8'h02, "R7 capture flag cleared by reset");
        rd(4'd6, 8'h00, 8'hFF, "R7 capture high cleared");
        rd(4'd7, 8'h00, 8'hFF, "R7 capture low cleared");
        // compare
        wait_to(20);
        rd(4'd1, 8'h00, 8'h04, "R9 no compare before first low write");
        pk(1, 1'b0, "R9 pin idle before first low write");
        wr(4'd0, 8'h02);
        wr(4'd8, 8'h00);
        wr(4'd9, 8'h24);
        wait_to(150);
        pk(1, 1'b0, "R8 pin before match");
        rd(4'd1, 8'h00, 8'h04, "R8 flag before match");
        wait_to(161);
        pk(1, 1'b1, "R8 pin high on match");
        rd(4'd1, 8'h04, 8'h04, "R8 compare flag set");
        wr(4'd9, 8'h30);
        rd(4'd1, 8'h00, 8'h04, "R10 compare flag cleared");
        wr(4'd0, 8'h00);
        wr(4'd8, 8'h00);
        wait_to(215);
        pk(1, 1'b1, "R9 blocked compare leaves pin");
        rd(4'd1, 8'h00, 8'h04, "R9 blocked compare leaves flag");
        wr(4'd9, 8'h38);
        wait_to(242);
        pk(1, 1'b0, "R8 pin low on match");
        wr(4'd9, 8'h38);
        wr(4'd0, 8'h10);
        pk(2, 1'b1, "R11 compare interrupt");
        rd(4'd1, 8'h04, 8'h04, "R10 flag kept without status read");
        wr(4'd9, 8'h80);
        rd(4'd1, 8'h00, 8'h04, "R10 compare flag cleared");
        pk(2, 1'b0, "R11 interrupt drops after clear");
        idle(2);
        summary();
    end
endmodule